// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces data-memory addresses for signal-processing loops. It keeps sixteen pointer sets, split into a primary bank of eight and a secondary bank of eight. Each set holds four values: an index (the running pointer), a signed modify step, a buffer length and a buffer base. A bank-select input picks which bank every access and every register write uses, so a context switch costs no cycles.

Each access request names a set and an addressing mode. There are four modes: immediate, indirect with pre-modify, indirect with post-modify, and post-modify with bit-reversed output. The block returns the address one cycle later. It can also update the set's index in that same cycle. A non-zero length keeps the pointer inside the range [base, base+length). The buffer may start at any address and may have any length. When the pointer runs past either end, the length is added or subtracted, and this costs no extra cycles. A length of zero gives plain linear stepping.

Top module: `circ_agen`

## Requirements
- R1: After reset `addr_valid` is 0, `addr` is 0, and every index, modify, length and base register reads as 0.
- R2: Mode 2'b01 (pre-modify) returns the stepped address index+modify (wrapped as in R4) and leaves the index unchanged.
- R3: Mode 2'b10 (post-modify) returns the current index and then replaces the index with the stepped value (wrapped as in R4).
- R4: With a non-zero length, a stepped value at or above base+length has length subtracted, and one below base has length added. The modify step is two's complement and its magnitude is at most the length. Base and length need no alignment.
- R5: With length 0 the stepped value is index+modify, taken modulo 2^AW, with no wraparound.
- R6: Mode 2'b00 (immediate) returns `imm_addr` and changes no register.
- R7: Mode 2'b11 (bit-reverse) returns base plus the low BRW index bits in reversed order (bit 0 becomes bit BRW-1). The index then becomes index+modify, with no wraparound.
- R8: `addr_valid` is 1 in exactly the cycle after a cycle with `req` high, and `addr` changes only in that cycle.
- R9: `bank_sel`=0 selects the primary bank and 1 selects the secondary bank, for both accesses and writes. Sets with the same number in the two banks are independent.
- R10: A register write uses `wr_reg` as follows: 2'b00 index, 2'b01 modify, 2'b10 length, 2'b11 base. Writing the base also loads the index with the same value.
- R11: When a write to a set's index or base lands in the same cycle as an index update of that set, the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 1 | 0 primary bank, 1 secondary bank |
| wr_en | input | 1 | Register write strobe |
| wr_set | input | $clog2(NSETS) | Set number written |
| wr_reg | input | 2 | Register selector (R10) |
| wr_data | input | AW | Write value |
| req | input | 1 | Access request |
| req_set | input | $clog2(NSETS) | Set number accessed |
| mode | input | 2 | Addressing mode (R2, R3, R6, R7) |
| imm_addr | input | AW | Address for immediate mode |
| addr_valid | output | 1 | Address valid strobe |
| addr | output | AW | Generated address |

## Verification
An address is due on the first rising edge after the request cycle, so the bench drives each request on a falling edge. It then reads `addr` and `addr_valid` on the following falling edge. Index updates and register writes take effect at that same edge, so the next access made one cycle later already sees the new index. The bench checks each index update by the address that the following access returns, never by looking inside the design. Each wrap sequence, including the sequences with negative steps and odd bases, is computed by hand in the bench.

// File: rtl/circ_agen.sv
module circ_agen #(
  parameter int AW    = 16,
  parameter int NSETS = 8,
  parameter int BRW   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bank_sel,
  input  logic                     wr_en,
  input  logic [$clog2(NSETS)-1:0] wr_set,
  input  logic [1:0]               wr_reg,
  input  logic [AW-1:0]            wr_data,
  input  logic                     req,
  input  logic [$clog2(NSETS)-1:0] req_set,
  input  logic [1:0]               mode,
  input  logic [AW-1:0]            imm_addr,
  output logic                     addr_valid,
  output logic [AW-1:0]            addr
);
  localparam int SW   = $clog2(NSETS);
  localparam int PW   = SW + 1;
  localparam int NPTR = 2 * NSETS;

  localparam logic [1:0] M_IMM = 2'b00;
  localparam logic [1:0] M_PRE = 2'b01;
  localparam logic [1:0] M_PST = 2'b10;
  localparam logic [1:0] M_REV = 2'b11;

  localparam logic [1:0] G_IDX = 2'b00;
  localparam logic [1:0] G_MOD = 2'b01;
  localparam logic [1:0] G_LEN = 2'b10;
  localparam logic [1:0] G_BAS = 2'b11;

  logic [AW-1:0] idx_r [NPTR];
  logic [AW-1:0] mod_r [NPTR];
  logic [AW-1:0] len_r [NPTR];
  logic [AW-1:0] bas_r [NPTR];

  logic [PW-1:0] rptr, wptr;
  assign rptr = {bank_sel, req_set};
  assign wptr = {bank_sel, wr_set};

  logic [AW-1:0] cur_i, cur_m, cur_l, cur_b;
  assign cur_i = idx_r[rptr];
  assign cur_m = mod_r[rptr];
  assign cur_l = len_r[rptr];
  assign cur_b = bas_r[rptr];

  // signed arithmetic two bits wider than the address, so both overrun directions are visible
  logic signed [AW+1:0] s_sum, s_lo, s_hi, s_len;
  logic [AW-1:0]        stepped;
  assign s_sum = $signed({2'b00, cur_i}) + $signed({{2{cur_m[AW-1]}}, cur_m});
  assign s_lo  = $signed({2'b00, cur_b});
  assign s_len = $signed({2'b00, cur_l});
  assign s_hi  = s_lo + s_len;

  logic signed [AW+1:0] s_wrap;
  always_comb begin
    s_wrap = s_sum;
    if (cur_l != '0) begin
      if (s_sum >= s_hi)      s_wrap = s_sum - s_len;
      else if (s_sum < s_lo)  s_wrap = s_sum + s_len;
    end
  end
  assign stepped = s_wrap[AW-1:0];

  logic [AW-1:0] linear;
  assign linear = cur_i + cur_m;

  logic [BRW-1:0] rev_bits;
  for (genvar g = 0; g < BRW; g++) begin : g_rev
    assign rev_bits[g] = cur_i[BRW-1-g];
  end

  logic [AW-1:0] rev_addr;
  assign rev_addr = cur_b + {{(AW-BRW){1'b0}}, rev_bits};

  logic [AW-1:0] addr_nx;
  always_comb begin
    case (mode)
      M_IMM:   addr_nx = imm_addr;
      M_PRE:   addr_nx = stepped;
      M_PST:   addr_nx = cur_i;
      default: addr_nx = rev_addr;
    endcase
  end

  logic          upd_en;
  logic [AW-1:0] upd_val;
  assign upd_en  = req && (mode == M_PST || mode == M_REV);
  assign upd_val = (mode == M_REV) ? linear : stepped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NPTR; k++) begin
        idx_r[k] <= '0;
        mod_r[k] <= '0;
        len_r[k] <= '0;
        bas_r[k] <= '0;
      end
    end else begin
      if (upd_en) idx_r[rptr] <= upd_val;
      if (wr_en) begin
        case (wr_reg)
          G_IDX: idx_r[wptr] <= wr_data;
          G_MOD: mod_r[wptr] <= wr_data;
          G_LEN: len_r[wptr] <= wr_data;
          default: begin
            bas_r[wptr] <= wr_data;
            idx_r[wptr] <= wr_data;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr       <= '0;
    end else begin
      addr_valid <= req;
      if (req) addr <= addr_nx;
    end
  end

  AST_VALID_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> addr_valid); // R8
  AST_ADDR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(addr)); // R8
  AST_IMM_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == M_IMM) |=> addr == $past(imm_addr)); // R6
  AST_PRE_KEEPS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == M_PRE && !wr_en) |=> idx_r[$past(rptr)] == $past(cur_i)); // R2
  AST_WRAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == M_PST && !wr_en && cur_l != '0 && cur_i >= cur_b
     && s_sum < s_hi && $signed({2'b00, cur_i}) >= s_lo
     && $signed({2'b00, cur_i}) < s_hi && !s_hi[AW+1] && s_hi <= $signed({2'b00, {AW{1'b1}}}))
    |=> (idx_r[$past(rptr)] >= bas_r[$past(rptr)]
         && {1'b0, idx_r[$past(rptr)]} < {1'b0, bas_r[$past(rptr)]} + {1'b0, len_r[$past(rptr)]})); // R4
  AST_BASE_LOADS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_reg == G_BAS) |=> idx_r[$past(wptr)] == $past(wr_data)); // R10
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_reg == G_IDX && upd_en && wptr == rptr) |=> idx_r[$past(wptr)] == $past(wr_data)); // R11
endmodule

// File: tb/circ_agen_tb.sv
module circ_agen_tb;
  localparam int AW = 16;
  localparam int NSETS = 8;
  localparam int BRW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bank_sel = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_set = '0;
  logic [1:0] wr_reg = '0;
  logic [AW-1:0] wr_data = '0;
  logic req = 1'b0;
  logic [2:0] req_set = '0;
  logic [1:0] mode = '0;
  logic [AW-1:0] imm_addr = '0;
  logic addr_valid;
  logic [AW-1:0] addr;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  circ_agen #(.AW(AW), .NSETS(NSETS), .BRW(BRW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .wr_en(wr_en), .wr_set(wr_set),
    .wr_reg(wr_reg), .wr_data(wr_data), .req(req), .req_set(req_set), .mode(mode),
    .imm_addr(imm_addr), .addr_valid(addr_valid), .addr(addr));

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic b, input int s, input logic [1:0] r, input logic [AW-1:0] d);
    @(negedge clk);
    bank_sel = b; wr_en = 1'b1; wr_set = 3'(s); wr_reg = r; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input logic b, input int s, input logic [AW-1:0] base,
                       input logic [AW-1:0] len, input logic [AW-1:0] step);
    wreg(b, s, 2'b10, len);
    wreg(b, s, 2'b01, step);
    wreg(b, s, 2'b11, base);
  endtask

  task automatic acc(input string tag, input logic b, input int s, input logic [1:0] m,
                     input logic [AW-1:0] imm, input logic [AW-1:0] exp);
    @(negedge clk);
    bank_sel = b; req = 1'b1; req_set = 3'(s); mode = m; imm_addr = imm;
    @(negedge clk);
    req = 1'b0;
    check({tag, " valid"}, AW'(addr_valid), AW'(1));
    check(tag, addr, exp);
  endtask

  task automatic t_reset;
    check("R1 valid after reset", AW'(addr_valid), '0);
    check("R1 addr after reset", addr, '0);
    acc("R1 zero index post", 1'b0, 5, 2'b10, '0, 16'd0);
  endtask

  task automatic t_immediate;
    setup(1'b0, 0, 16'd40, 16'd0, 16'd1);
    acc("R6 immediate", 1'b0, 0, 2'b00, 16'hBEEF, 16'hBEEF);
    acc("R6 index untouched", 1'b0, 0, 2'b10, '0, 16'd40);
    @(negedge clk);
    check("R8 valid drops", AW'(addr_valid), '0);
    check("R8 addr held", addr, 16'd40);
  endtask

  task automatic t_linear;
    setup(1'b0, 1, 16'd100, 16'd0, 16'd4);
    acc("R3 post 0", 1'b0, 1, 2'b10, '0, 16'd100);
    acc("R3 post 1", 1'b0, 1, 2'b10, '0, 16'd104);
    acc("R5 post 2", 1'b0, 1, 2'b10, '0, 16'd108);
    setup(1'b0, 1, 16'hFFFE, 16'd0, 16'd3);
    acc("R5 rollover a", 1'b0, 1, 2'b10, '0, 16'hFFFE);
    acc("R5 rollover b", 1'b0, 1, 2'b10, '0, 16'd1);
  endtask

  task automatic t_pre;
    setup(1'b0, 2, 16'd200, 16'd0, 16'd8);
    acc("R2 pre a", 1'b0, 2, 2'b01, '0, 16'd208);
    acc("R2 pre b", 1'b0, 2, 2'b01, '0, 16'd208);
    setup(1'b0, 2, 16'd300, 16'd4, 16'd3);
    wreg(1'b0, 2, 2'b00, 16'd303);
    acc("R2 pre wraps", 1'b0, 2, 2'b01, '0, 16'd302);
    acc("R2 index kept", 1'b0, 2, 2'b10, '0, 16'd303);
  endtask

  task automatic t_wrap_up;
    logic [AW-1:0] exp [6] = '{16'd1003, 16'd1005, 16'd1007, 16'd1004, 16'd1006, 16'd1003};
    setup(1'b0, 3, 16'd1003, 16'd5, 16'd2);
    for (int k = 0; k < 6; k++) acc($sformatf("R4 up %0d", k), 1'b0, 3, 2'b10, '0, exp[k]);
  endtask

  task automatic t_wrap_down;
    logic [AW-1:0] exp [4] = '{16'd50, 16'd52, 16'd54, 16'd50};
    setup(1'b0, 4, 16'd50, 16'd6, -16'sd4);
    for (int k = 0; k < 4; k++) acc($sformatf("R4 down %0d", k), 1'b0, 4, 2'b10, '0, exp[k]);
  endtask

  task automatic t_bitrev;
    logic [AW-1:0] exp [5] = '{16'h400, 16'h408, 16'h404, 16'h40C, 16'h402};
    setup(1'b0, 6, 16'h400, 16'd0, 16'd1);
    for (int k = 0; k < 5; k++) acc($sformatf("R7 rev %0d", k), 1'b0, 6, 2'b11, '0, exp[k]);
  endtask

  task automatic t_banks;
    setup(1'b0, 7, 16'd10, 16'd0, 16'd1);
    setup(1'b1, 7, 16'd500, 16'd0, 16'd2);
    acc("R9 secondary a", 1'b1, 7, 2'b10, '0, 16'd500);
    acc("R9 secondary b", 1'b1, 7, 2'b10, '0, 16'd502);
    acc("R9 primary intact", 1'b0, 7, 2'b10, '0, 16'd10);
    acc("R9 secondary next", 1'b1, 7, 2'b10, '0, 16'd504);
  endtask

  task automatic t_collide;
    setup(1'b0, 5, 16'd60, 16'd0, 16'd1);
    @(negedge clk);
    bank_sel = 1'b0; req = 1'b1; req_set = 3'd5; mode = 2'b10;
    wr_en = 1'b1; wr_set = 3'd5; wr_reg = 2'b00; wr_data = 16'd77;
    @(negedge clk);
    req = 1'b0; wr_en = 1'b0;
    check("R11 old index out", addr, 16'd60);
    acc("R11 write wins", 1'b0, 5, 2'b10, '0, 16'd77);
    acc("R10 index step", 1'b0, 5, 2'b10, '0, 16'd78);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_immediate();
    t_linear();
    t_pre();
    t_wrap_up();
    t_wrap_down();
    t_bitrev();
    t_banks();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule